// File: doc/BRIEF.md
# Load-Linked Reservation Monitor

This block keeps the exclusive reservations that load-linked reads from several hardware contexts set up, and it decides whether later store-conditional writes succeed. Each reservation records a context number and a granule address. An address is first reduced to its reservation granule, so any byte inside one granule hits the same reservation. Each context holds at most one reservation.

The block has two event inputs. A load-linked event installs or moves the context's reservation. A write event is either a plain store or a conditional store. One cycle after a write event the block reports whether the store may go to memory and whether a conditional store succeeded. It also returns a bitmask of the other contexts whose reservations that write removed, so their exclusive state can be cleared. The reservation table has a fixed number of slots. When a load-linked finds the table full, the entry that was allocated earliest is dropped.

Top module: `resv_monitor`

## Requirements
- R1: Address bits below GRAN_LSB are ignored. Two addresses that differ only in those bits refer to the same reservation.
- R2: A load-linked from a context that already holds a reservation moves that reservation to the new granule and takes no new slot. The old granule is then no longer reserved for that context.
- R3: A load-linked from a context without a reservation takes a new slot. Several contexts may hold reservations on the same granule.
- R4: A plain store (wr_cond=0) always reports wr_ok=1 and sc_pass=0.
- R5: A conditional store (wr_cond=1) reports wr_ok=1 and sc_pass=1 only when a valid entry matches both its context and its granule. Otherwise it reports wr_ok=0 and sc_pass=0.
- R6: An allowed store, whether plain or a successful conditional, removes every reservation on its granule whatever the owning context. A later conditional store to that granule by any of those contexts then fails.
- R7: A failed conditional store removes no reservation and reports clr_excl=0.
- R8: clr_excl bit c is 1 exactly when the write removed the reservation of context c and c differs from the writing context. The writer's own bit is never set.
- R9: A load-linked that needs a new slot while all ENTRIES slots are in use drops the entry allocated earliest. A conditional store that relied on the dropped entry then fails.
- R10: Results are registered. wr_done, wr_ok, sc_pass and clr_excl describe the write event of the previous cycle. In a cycle after no write event all four are 0.
- R11: When a load-linked and a write arrive in the same cycle, the write is judged against the table first. The load-linked is then applied, so its reservation survives that write.
- R12: A synchronous active-high reset clears every reservation and drives all outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ll_valid | input | 1 | Load-linked event this cycle |
| ll_ctx | input | CTX_W | Context issuing the load-linked |
| ll_addr | input | ADDR_W | Physical address of the load-linked |
| wr_valid | input | 1 | Write event this cycle |
| wr_ctx | input | CTX_W | Context issuing the write |
| wr_addr | input | ADDR_W | Physical address of the write |
| wr_cond | input | 1 | 1 = conditional store, 0 = plain store |
| wr_done | output | 1 | A write was judged in the previous cycle |
| wr_ok | output | 1 | That write may update memory |
| sc_pass | output | 1 | That write was a conditional store that succeeded |
| clr_excl | output | NUM_CTX | Other contexts whose reservations that write removed |

## Verification
The bench builds the block with four contexts but only three table slots. With this setting a fourth distinct context overflows the table, so the eviction order can be checked. GRAN_LSB is 3, which gives eight-byte granules. Addresses seven bytes apart therefore fall into one granule and addresses eight bytes apart into two, which probes the masking at both edges. Sequences that place several contexts on one granule reach the multi-bit clear mask, the same-cycle ordering and the rule that a failed conditional store leaves the table alone.

// File: rtl/resv_pkg.sv
package resv_pkg;

    typedef enum logic [1:0] {
        WR_NONE  = 2'd0,
        WR_PLAIN = 2'd1,
        WR_COND  = 2'd2
    } wr_kind_e;

endpackage

// File: rtl/resv_match.sv
// Per-slot comparison of a query against the reservation table.
module resv_match #(
    parameter int ENTRIES = 4,
    parameter int TAG_W   = 13,
    parameter int CTX_W   = 2
) (
    input  logic [ENTRIES-1:0]            vld,
    input  logic [ENTRIES-1:0][TAG_W-1:0] tags,
    input  logic [ENTRIES-1:0][CTX_W-1:0] ctxs,
    input  logic [TAG_W-1:0]              q_tag,
    input  logic [CTX_W-1:0]              q_ctx,
    output logic [ENTRIES-1:0]            tag_hit,
    output logic [ENTRIES-1:0]            ctx_hit
);
    for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
        assign tag_hit[i] = vld[i] && (tags[i] == q_tag);
        assign ctx_hit[i] = vld[i] && (ctxs[i] == q_ctx);
    end
endmodule

// File: rtl/resv_update.sv
// Compacts surviving entries (slot 0 = newest) and applies a load-linked.
module resv_update #(
    parameter int ENTRIES = 4,
    parameter int TAG_W   = 13,
    parameter int CTX_W   = 2
) (
    input  logic [ENTRIES-1:0]            vld_in,
    input  logic [ENTRIES-1:0][TAG_W-1:0] tags_in,
    input  logic [ENTRIES-1:0][CTX_W-1:0] ctxs_in,
    input  logic                          ll_en,
    input  logic [TAG_W-1:0]              ll_tag,
    input  logic [CTX_W-1:0]              ll_ctx,
    output logic [ENTRIES-1:0]            vld_out,
    output logic [ENTRIES-1:0][TAG_W-1:0] tags_out,
    output logic [ENTRIES-1:0][CTX_W-1:0] ctxs_out
);
    logic [ENTRIES-1:0]            cv;
    logic [ENTRIES-1:0][TAG_W-1:0] ct;
    logic [ENTRIES-1:0][CTX_W-1:0] cc;
    logic                          own_hit;

    // Pack valid entries toward slot 0 while keeping their age order.
    always_comb begin
        int unsigned pre;
        cv = '0;
        ct = '0;
        cc = '0;
        pre = 0;
        for (int j = 0; j < ENTRIES; j++) begin
            for (int k = 0; k < ENTRIES; k++) begin
                if (vld_in[j] && pre == k) begin
                    cv[k] = 1'b1;
                    ct[k] = tags_in[j];
                    cc[k] = ctxs_in[j];
                end
            end
            if (vld_in[j]) pre = pre + 1;
        end
    end

    always_comb begin
        own_hit  = 1'b0;
        vld_out  = cv;
        tags_out = ct;
        ctxs_out = cc;
        if (ll_en) begin
            for (int k = 0; k < ENTRIES; k++) begin
                if (cv[k] && cc[k] == ll_ctx) begin
                    own_hit     = 1'b1;
                    tags_out[k] = ll_tag;
                end
            end
            if (!own_hit) begin
                vld_out[0]  = 1'b1;
                tags_out[0] = ll_tag;
                ctxs_out[0] = ll_ctx;
                for (int k = 1; k < ENTRIES; k++) begin
                    vld_out[k]  = cv[k-1];
                    tags_out[k] = ct[k-1];
                    ctxs_out[k] = cc[k-1];
                end
            end
        end
    end
endmodule

// File: rtl/resv_monitor.sv
module resv_monitor #(
    parameter int NUM_CTX  = 4,
    parameter int ENTRIES  = 4,
    parameter int ADDR_W   = 16,
    parameter int GRAN_LSB = 3,
    localparam int CTX_W   = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               ll_valid,
    input  logic [CTX_W-1:0]   ll_ctx,
    input  logic [ADDR_W-1:0]  ll_addr,
    input  logic               wr_valid,
    input  logic [CTX_W-1:0]   wr_ctx,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic               wr_cond,
    output logic               wr_done,
    output logic               wr_ok,
    output logic               sc_pass,
    output logic [NUM_CTX-1:0] clr_excl
);
    import resv_pkg::*;

    localparam int TAG_W = ADDR_W - GRAN_LSB;

    typedef struct packed {
        logic [ENTRIES-1:0]            vld;
        logic [ENTRIES-1:0][TAG_W-1:0] tag;
        logic [ENTRIES-1:0][CTX_W-1:0] ctx;
        logic                          done;
        logic                          ok;
        logic                          sc;
        logic [NUM_CTX-1:0]            clr;
    } state_t;

    state_t st_d, st_q;

    logic [TAG_W-1:0]              wr_tag, ll_tag;
    logic [ENTRIES-1:0]            tag_hit, ctx_hit, erase, kept;
    logic [ENTRIES-1:0]            upd_vld;
    logic [ENTRIES-1:0][TAG_W-1:0] upd_tag;
    logic [ENTRIES-1:0][CTX_W-1:0] upd_ctx;
    wr_kind_e                      kind;
    logic                          sc_hit, allow;

    assign wr_tag = wr_addr[ADDR_W-1:GRAN_LSB];
    assign ll_tag = ll_addr[ADDR_W-1:GRAN_LSB];

    resv_match #(.ENTRIES(ENTRIES), .TAG_W(TAG_W), .CTX_W(CTX_W)) i_match (
        .vld     (st_q.vld),
        .tags    (st_q.tag),
        .ctxs    (st_q.ctx),
        .q_tag   (wr_tag),
        .q_ctx   (wr_ctx),
        .tag_hit (tag_hit),
        .ctx_hit (ctx_hit)
    );

    always_comb begin
        if (!wr_valid)    kind = WR_NONE;
        else if (wr_cond) kind = WR_COND;
        else              kind = WR_PLAIN;
        sc_hit = |(tag_hit & ctx_hit);
        allow  = (kind == WR_PLAIN) || (kind == WR_COND && sc_hit);
        erase  = allow ? tag_hit : '0;
        kept   = st_q.vld & ~erase;
    end

    resv_update #(.ENTRIES(ENTRIES), .TAG_W(TAG_W), .CTX_W(CTX_W)) i_update (
        .vld_in   (kept),
        .tags_in  (st_q.tag),
        .ctxs_in  (st_q.ctx),
        .ll_en    (ll_valid),
        .ll_tag   (ll_tag),
        .ll_ctx   (ll_ctx),
        .vld_out  (upd_vld),
        .tags_out (upd_tag),
        .ctxs_out (upd_ctx)
    );

    always_comb begin
        st_d      = st_q;
        st_d.vld  = upd_vld;
        st_d.tag  = upd_tag;
        st_d.ctx  = upd_ctx;
        st_d.done = (kind != WR_NONE);
        st_d.ok   = allow;
        st_d.sc   = (kind == WR_COND) && sc_hit;
        st_d.clr  = '0;
        for (int c = 0; c < NUM_CTX; c++) begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (erase[i] && st_q.ctx[i] == CTX_W'(c) && wr_ctx != CTX_W'(c))
                    st_d.clr[c] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign wr_done  = st_q.done;
    assign wr_ok    = st_q.ok;
    assign sc_pass  = st_q.sc;
    assign clr_excl = st_q.clr;
endmodule

// File: rtl/resv_monitor_chk.sv
module resv_monitor_chk #(
    parameter int NUM_CTX  = 4,
    parameter int ENTRIES  = 4,
    parameter int ADDR_W   = 16,
    parameter int GRAN_LSB = 3,
    localparam int CTX_W   = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1
) (
    input logic               clk,
    input logic               rst,
    input logic               ll_valid,
    input logic [CTX_W-1:0]   ll_ctx,
    input logic [ADDR_W-1:0]  ll_addr,
    input logic               wr_valid,
    input logic [CTX_W-1:0]   wr_ctx,
    input logic [ADDR_W-1:0]  wr_addr,
    input logic               wr_cond,
    input logic               wr_done,
    input logic               wr_ok,
    input logic               sc_pass,
    input logic [NUM_CTX-1:0] clr_excl
);
    a_r4_plain_allowed: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && !wr_cond) |=> (wr_ok && !sc_pass));

    a_r5_pass_implies_ok: assert property (@(posedge clk) disable iff (rst)
        sc_pass |-> (wr_done && wr_ok));

    a_r7_fail_no_clear: assert property (@(posedge clk) disable iff (rst)
        (wr_done && !wr_ok) |-> (clr_excl == '0));

    a_r8_writer_not_cleared: assert property (@(posedge clk) disable iff (rst)
        wr_valid |=> !clr_excl[$past(wr_ctx)]);

    a_r10_done_follows: assert property (@(posedge clk) disable iff (rst)
        wr_valid |=> wr_done);

    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !wr_valid |=> (!wr_done && !wr_ok && !sc_pass && clr_excl == '0));

    a_r12_reset_clears: assert property (@(posedge clk)
        rst |=> (!wr_done && !wr_ok && !sc_pass && clr_excl == '0));
endmodule

bind resv_monitor resv_monitor_chk #(
    .NUM_CTX(NUM_CTX), .ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .GRAN_LSB(GRAN_LSB)
) i_chk (
    .clk(clk), .rst(rst), .ll_valid(ll_valid), .ll_ctx(ll_ctx), .ll_addr(ll_addr),
    .wr_valid(wr_valid), .wr_ctx(wr_ctx), .wr_addr(wr_addr), .wr_cond(wr_cond),
    .wr_done(wr_done), .wr_ok(wr_ok), .sc_pass(sc_pass), .clr_excl(clr_excl)
);

// File: tb/test_resv_monitor.sv
`timescale 1ns/100ps
module test_resv_monitor;
    localparam int NUM_CTX = 4;
    localparam int ENTRIES = 3;
    localparam int ADDR_W  = 16;
    localparam int GRAN    = 3;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              ll_valid = 1'b0;
    logic [1:0]        ll_ctx = '0;
    logic [ADDR_W-1:0] ll_addr = '0;
    logic              wr_valid = 1'b0;
    logic [1:0]        wr_ctx = '0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic              wr_cond = 1'b0;
    logic              wr_done, wr_ok, sc_pass;
    logic [NUM_CTX-1:0] clr_excl;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    resv_monitor #(.NUM_CTX(NUM_CTX), .ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .GRAN_LSB(GRAN))
    i_resv_monitor (
        .clk(clk), .rst(rst), .ll_valid(ll_valid), .ll_ctx(ll_ctx), .ll_addr(ll_addr),
        .wr_valid(wr_valid), .wr_ctx(wr_ctx), .wr_addr(wr_addr), .wr_cond(wr_cond),
        .wr_done(wr_done), .wr_ok(wr_ok), .sc_pass(sc_pass), .clr_excl(clr_excl)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic do_ll(int c, int a);
        ll_valid = 1'b1; ll_ctx = 2'(c); ll_addr = ADDR_W'(a);
        @(negedge clk);
        ll_valid = 1'b0;
    endtask

    // Issues one write, then samples the registered result one cycle later.
    task automatic do_wr(string req, int c, int a, bit cond, bit e_ok, bit e_sc, int e_clr);
        wr_valid = 1'b1; wr_ctx = 2'(c); wr_addr = ADDR_W'(a); wr_cond = cond;
        @(negedge clk);
        wr_valid = 1'b0; wr_cond = 1'b0;
        check({req, " done"}, 32'(wr_done), 32'd1);
        check({req, " ok"},   32'(wr_ok),   32'(e_ok));
        check({req, " sc"},   32'(sc_pass), 32'(e_sc));
        check({req, " clr"},  32'(clr_excl), 32'(e_clr));
    endtask

    task automatic t_reset();
        do_ll(1, 'h200);
        do_reset();
        check("R12 done", 32'(wr_done), 0);
        check("R12 ok", 32'(wr_ok), 0);
        check("R12 clr", 32'(clr_excl), 0);
        do_wr("R12 reservation gone", 1, 'h200, 1, 0, 0, 0);
    endtask

    task automatic t_plain();
        do_reset();
        do_wr("R4 plain no resv", 2, 'h40, 0, 1, 0, 0);
        @(negedge clk);
        check("R10 idle done", 32'(wr_done), 0);
        check("R10 idle clr", 32'(clr_excl), 0);
    endtask

    task automatic t_granule();
        do_reset();
        do_ll(3, 'h100);
        do_wr("R1 same granule", 3, 'h107, 1, 1, 1, 0);
        do_ll(3, 'h100);
        do_wr("R1 next granule", 3, 'h108, 1, 0, 0, 0);
        do_wr("R5 own match", 3, 'h100, 1, 1, 1, 0);
        do_wr("R5 no entry", 0, 'h100, 1, 0, 0, 0);
    endtask

    task automatic t_replace();
        do_reset();
        do_ll(1, 'h300);
        do_ll(0, 'h100);
        do_ll(0, 'h180);
        do_ll(2, 'h400);
        do_wr("R2 old granule", 0, 'h100, 1, 0, 0, 0);
        do_wr("R2 no extra slot", 1, 'h300, 1, 1, 1, 0);
        do_wr("R2 new granule", 0, 'h180, 1, 1, 1, 0);
        do_wr("R3 third ctx", 2, 'h400, 1, 1, 1, 0);
    endtask

    task automatic t_fail_and_clear();
        do_reset();
        do_ll(0, 'h500);
        do_ll(1, 'h500);
        do_ll(2, 'h600);
        do_wr("R7 failed sc", 3, 'h500, 1, 0, 0, 0);
        do_wr("R8 sc clears other", 0, 'h500, 1, 1, 1, 'b0010);
        do_wr("R6 other erased", 1, 'h500, 1, 0, 0, 0);
        do_ll(0, 'h600);
        do_ll(1, 'h600);
        do_wr("R8 plain clears many", 3, 'h604, 0, 1, 0, 'b0111);
        do_wr("R6 plain erased", 2, 'h600, 1, 0, 0, 0);
    endtask

    task automatic t_evict();
        do_reset();
        do_ll(0, 'h10);
        do_ll(1, 'h20);
        do_ll(2, 'h30);
        do_ll(3, 'h40);
        do_wr("R9 oldest dropped", 0, 'h10, 1, 0, 0, 0);
        do_wr("R9 survivor 1", 1, 'h20, 1, 1, 1, 0);
        do_wr("R9 survivor 3", 3, 'h40, 1, 1, 1, 0);
    endtask

    task automatic t_same_cycle();
        do_reset();
        do_ll(0, 'h700);
        ll_valid = 1'b1; ll_ctx = 2'd1; ll_addr = 'h700;
        do_wr("R11 write first", 2, 'h700, 0, 1, 0, 'b0001);
        do_wr("R11 old erased", 0, 'h700, 1, 0, 0, 0);
        do_wr("R11 new kept", 1, 'h700, 1, 1, 1, 0);
    endtask

    initial begin
        do_reset();
        t_reset();
        t_plain();
        t_granule();
        t_replace();
        t_fail_and_clear();
        t_evict();
        t_same_cycle();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule